// File: doc/BRIEF.md
# Keyed Register Write-Protection Controller

This block guards groups of sensitive peripheral registers against accidental writes. It holds a 16-bit protection-control register on a simple register bus. Three bits of that register each unlock one group of registers: clock generation, low-power control and voltage detection. Software changes the register only by writing it as one full 16-bit word whose upper byte carries the unlock key `8'hA5`. The lower byte of that word supplies the new release bits.

Every bus write that the address decoder routes to a protected range passes through the block, together with a group code. The block forwards the write strobe only when the release bit for that group is set. A write into a locked group is dropped and sets a sticky violation flag. The flag sits in a second bus register and is cleared by writing 1 to it. Reads of protected registers never go through the block, so they are never blocked.

Top module: `wprot_ctrl`

## Requirements
- R1: After reset all release bits are 0, so every group is locked, and the violation flag is 0.
- R2: A write to address 0 with both byte enables set and `wdata[15:8] == 8'hA5` loads `wdata[7:0]`, masked to the implemented bits, into the release bits. The new value shows on `rd_data` from the cycle after the write edge.
- R3: A write to address 0 whose upper byte is not `8'hA5` leaves the release bits unchanged and does not set the violation flag.
- R4: A write to address 0 with either byte enable low is ignored, even when the key is correct.
- R5: Release bit 0 unlocks group code 1 (clock). Bit 1 unlocks group code 2 (low-power). Bit 3 unlocks group code 3 (voltage detection). Group code 0 means the address is not protected.
- R6: Bits 2 and 4 to 7 of the control register always read 0. A read of address 0 returns `8'h00` in bits [15:8], because the key is not stored.
- R7: `grp_wr_out` follows `grp_wr_in` in the same cycle when the group code is 0 or the selected group's release bit is 1. Otherwise it is held low.
- R8: A `grp_wr_in` pulse into a locked group sets the violation flag from the next cycle. The flag then stays set until it is cleared.
- R9: A write to address 1 with byte enable 0 set and `wdata[0] = 1` clears the violation flag; writing 0 leaves it unchanged. When a clear and a locked group write land on the same edge, the flag ends up set. Address 1 reads as `{15'b0, flag}`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe for this block |
| bus_addr | input | 1 | 0 selects the control register, 1 selects the violation register |
| bus_be | input | 2 | Byte enables, bit 1 for [15:8], bit 0 for [7:0] |
| bus_wdata | input | 16 | Write data |
| rd_data | output | 16 | Read data of the register selected by `bus_addr` |
| grp_sel | input | 2 | Group code from the address decoder: 0 none, 1 clock, 2 low-power, 3 voltage detection |
| grp_wr_in | input | 1 | Write strobe toward a decoded register |
| grp_wr_out | output | 1 | Gated write strobe |
| viol_flag | output | 1 | Sticky violation flag |

## Verification
Control writes are tried with the right key at full width, with a wrong key, and with each single byte enable. Together these separate a key check from a width check, because each faulty variant still lets one of those writes through. Each group code is then driven with its bit set, with only the other bits set, and with none set. This exposes a wrong bit-to-group mapping, and shows that code 0 passes regardless of the bits. The violation flag is exercised by writes of 1 and 0 to its register, by a same-edge clear and set, and by locked writes in different groups, so that a flag that is not sticky or that is set too readily stands out.

// File: rtl/wprot_pkg.sv
package wprot_pkg;

    localparam int REG_W   = 16;
    localparam int KEY_W   = 8;
    localparam int PROT_W  = REG_W - KEY_W;
    localparam int BE_W    = REG_W / 8;
    localparam logic [KEY_W-1:0]  UNLOCK_KEY = 8'hA5;
    localparam int N_GRP   = 3;
    localparam int GSEL_W  = $clog2(N_GRP + 1);

    // release-bit position for group codes 1..N_GRP
    localparam int GRP_BIT [N_GRP] = '{0, 1, 3};

    typedef enum logic [GSEL_W-1:0] {
        GRP_NONE = 2'd0,
        GRP_CLK  = 2'd1,
        GRP_PWR  = 2'd2,
        GRP_LVD  = 2'd3
    } grp_e;

    function automatic logic [PROT_W-1:0] impl_mask();
        logic [PROT_W-1:0] m;
        m = '0;
        for (int i = 0; i < N_GRP; i++) m[GRP_BIT[i]] = 1'b1;
        return m;
    endfunction

    localparam logic [PROT_W-1:0] PROT_MASK = impl_mask();

    typedef struct packed {
        logic [PROT_W-1:0] prot;
        logic              viol;
    } state_t;

endpackage

// File: rtl/wprot_key_check.sv
module wprot_key_check
    import wprot_pkg::*;
#(
    parameter int W  = REG_W,
    parameter int KW = KEY_W,
    parameter logic [KW-1:0] KEY = UNLOCK_KEY
) (
    input  logic            wr,
    input  logic [W/8-1:0]  be,
    input  logic [W-1:0]    wdata,
    output logic            accept
);
    localparam int KLO = W - KW;

    always_comb begin
        accept = wr && (&be) && (wdata[W-1:KLO] == KEY);
    end
endmodule

// File: rtl/wprot_gate.sv
module wprot_gate
    import wprot_pkg::*;
#(
    parameter int NG = N_GRP,
    parameter int PW = PROT_W,
    parameter int SW = GSEL_W
) (
    input  logic [PW-1:0] prot,
    input  logic [SW-1:0] sel,
    input  logic          wr_in,
    output logic          wr_out,
    output logic          locked_hit
);
    logic [NG:0] grp_en;

    assign grp_en[0] = 1'b1;   // code 0: unprotected range

    genvar gi;
    generate
        for (gi = 1; gi <= NG; gi++) begin : g_en
            assign grp_en[gi] = prot[GRP_BIT[gi-1]];
        end
    endgenerate

    always_comb begin
        wr_out     = wr_in &  grp_en[sel];
        locked_hit = wr_in & ~grp_en[sel];
    end
endmodule

// File: rtl/wprot_ctrl.sv
module wprot_ctrl
    import wprot_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_addr,
    input  logic [BE_W-1:0]   bus_be,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  rd_data,
    input  logic [GSEL_W-1:0] grp_sel,
    input  logic              grp_wr_in,
    output logic              grp_wr_out,
    output logic              viol_flag
);
    state_t st_d, st_q;
    logic   ctl_accept;
    logic   locked_hit;
    logic   viol_clr;

    wprot_key_check #(.W(REG_W), .KW(KEY_W), .KEY(UNLOCK_KEY)) u_key (
        .wr     (bus_wr && !bus_addr),
        .be     (bus_be),
        .wdata  (bus_wdata),
        .accept (ctl_accept)
    );

    wprot_gate #(.NG(N_GRP), .PW(PROT_W), .SW(GSEL_W)) u_gate (
        .prot       (st_q.prot),
        .sel        (grp_sel),
        .wr_in      (grp_wr_in),
        .wr_out     (grp_wr_out),
        .locked_hit (locked_hit)
    );

    always_comb begin
        viol_clr = bus_wr && bus_addr && bus_be[0] && bus_wdata[0];
        st_d = st_q;
        if (ctl_accept) st_d.prot = bus_wdata[PROT_W-1:0] & PROT_MASK;
        if (viol_clr)   st_d.viol = 1'b0;
        if (locked_hit) st_d.viol = 1'b1;   // set wins over clear
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        if (bus_addr) rd_data = {{(REG_W-1){1'b0}}, st_q.viol};
        else          rd_data = {{KEY_W{1'b0}}, st_q.prot};
        viol_flag = st_q.viol;
    end

    // wrong key never changes the control bits nor raises the flag
    assert_bad_key_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_addr && bus_wdata[REG_W-1:PROT_W] != UNLOCK_KEY && !locked_hit && !st_q.viol)
        |=> ($stable(st_q.prot) && !st_q.viol));

    // partial-width writes to the control register are dropped
    assert_byte_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_addr && !(&bus_be)) |=> $stable(st_q.prot));

    // unimplemented bits never become set
    assert_reserved_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.prot & ~PROT_MASK) == '0);

    // gated strobe never fires without the incoming strobe
    assert_gate_needs_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        grp_wr_out |-> grp_wr_in);

    // a dropped write raises the flag on the next cycle
    assert_viol_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_wr_in && !grp_wr_out) |=> viol_flag);

    // flag only drops through an explicit clear
    assert_viol_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_flag && !viol_clr) |=> viol_flag);

endmodule

// File: tb/wprot_ctrl_test.sv
module wprot_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_addr = 1'b0;
    logic [1:0]  bus_be = 2'b00;
    logic [15:0] bus_wdata = '0;
    logic [15:0] rd_data;
    logic [1:0]  grp_sel = 2'd0;
    logic        grp_wr_in = 1'b0;
    logic        grp_wr_out;
    logic        viol_flag;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    wprot_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .rd_data(rd_data),
        .grp_sel(grp_sel), .grp_wr_in(grp_wr_in), .grp_wr_out(grp_wr_out),
        .viol_flag(viol_flag)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // vector: kind(1) addr(1) be(2) data(16) gsel(2) exp_gate(1) exp_ctl(8) exp_viol(1)
    localparam int NV = 19;
    localparam logic [31:0] VEC [NV] = '{
        {1'b1,1'b0,2'b00,16'h0000,2'd1,1'b0,8'h00,1'b1}, // R8 R7 locked clock
        {1'b0,1'b1,2'b01,16'h0001,2'd0,1'b0,8'h00,1'b0}, // R9 clear
        {1'b0,1'b0,2'b11,16'hA501,2'd0,1'b0,8'h01,1'b0}, // R2 key write
        {1'b1,1'b0,2'b00,16'h0000,2'd1,1'b1,8'h01,1'b0}, // R5 clock open
        {1'b1,1'b0,2'b00,16'h0000,2'd2,1'b0,8'h01,1'b1}, // R5 low-power locked
        {1'b0,1'b1,2'b01,16'h0000,2'd0,1'b0,8'h01,1'b1}, // R9 write 0 keeps
        {1'b0,1'b1,2'b01,16'h0001,2'd0,1'b0,8'h01,1'b0}, // R9 clear
        {1'b0,1'b0,2'b11,16'h5A0B,2'd0,1'b0,8'h01,1'b0}, // R3 bad key
        {1'b0,1'b0,2'b01,16'hA50B,2'd0,1'b0,8'h01,1'b0}, // R4 low byte only
        {1'b0,1'b0,2'b10,16'hA50B,2'd0,1'b0,8'h01,1'b0}, // R4 high byte only
        {1'b0,1'b0,2'b11,16'hA5FF,2'd0,1'b0,8'h0B,1'b0}, // R6 reserved masked
        {1'b1,1'b0,2'b00,16'h0000,2'd3,1'b1,8'h0B,1'b0}, // R5 lvd open
        {1'b1,1'b0,2'b00,16'h0000,2'd2,1'b1,8'h0B,1'b0}, // R5 low-power open
        {1'b1,1'b0,2'b00,16'h0000,2'd0,1'b1,8'h0B,1'b0}, // R7 code 0
        {1'b0,1'b0,2'b11,16'hA508,2'd0,1'b0,8'h08,1'b0}, // R2 lvd only
        {1'b1,1'b0,2'b00,16'h0000,2'd1,1'b0,8'h08,1'b1}, // R5 clock locked
        {1'b1,1'b0,2'b00,16'h0000,2'd0,1'b1,8'h08,1'b1}, // R7 code 0 locked-all-else
        {1'b0,1'b0,2'b11,16'hA500,2'd0,1'b0,8'h00,1'b1}, // R2 relock
        {1'b1,1'b0,2'b00,16'h0000,2'd3,1'b0,8'h00,1'b1}  // R5 lvd locked
    };

    task automatic idle_bus();
        bus_wr = 1'b0; bus_addr = 1'b0; bus_be = 2'b00; bus_wdata = '0;
        grp_wr_in = 1'b0; grp_sel = 2'd0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        idle_bus();
        repeat (3) @(negedge clk);
        #1;
        check("R1 ctl", rd_data, 16'h0000);
        check("R1 viol", {15'b0, viol_flag}, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check("R1 ctl after release", rd_data, 16'h0000);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            if (VEC[i][31]) begin
                grp_sel = VEC[i][11:10];
                grp_wr_in = 1'b1;
            end else begin
                bus_wr = 1'b1;
                bus_addr = VEC[i][30];
                bus_be = VEC[i][29:28];
                bus_wdata = VEC[i][27:12];
            end
            #1;
            if (VEC[i][31])
                check($sformatf("R7 gate vec%0d", i), {15'b0, grp_wr_out}, {15'b0, VEC[i][9]});
            @(negedge clk);
            idle_bus();
            #1;
            check($sformatf("R2 ctl vec%0d", i), rd_data, {8'h00, VEC[i][8:1]});
            check($sformatf("R8 viol vec%0d", i), {15'b0, viol_flag}, {15'b0, VEC[i][0]});
        end

        // R9 address 1 readback, then same-edge clear and locked write: set wins
        @(negedge clk);
        bus_addr = 1'b1;
        #1;
        check("R9 status read", rd_data, 16'h0001);
        bus_wr = 1'b1; bus_be = 2'b01; bus_wdata = 16'h0001;
        grp_sel = 2'd1; grp_wr_in = 1'b1;
        @(negedge clk);
        idle_bus();
        #1;
        check("R9 set wins", {15'b0, viol_flag}, 16'h0001);

        // R6 upper byte of readback after full write is zero
        @(negedge clk);
        bus_wr = 1'b1; bus_be = 2'b11; bus_wdata = 16'hA5F4;
        @(negedge clk);
        idle_bus();
        #1;
        check("R6 readback", rd_data, 16'h0000);

        // R1 reset mid-run
        @(negedge clk);
        bus_wr = 1'b1; bus_be = 2'b11; bus_wdata = 16'hA503;
        @(negedge clk);
        idle_bus();
        rst_n = 1'b0;
        #1;
        check("R1 ctl mid reset", rd_data, 16'h0000);
        check("R1 viol mid reset", {15'b0, viol_flag}, 16'h0000);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule